// File: doc/BRIEF.md
# Eight-Operation 16-Bit ALU

This block is the purely combinational arithmetic and logic unit of a small single-cycle processor core. It takes two operands and a 3-bit operation selector. In the same cycle it returns a result word and a flag that is high when that result is zero. The core's branch logic uses the flag to decide whether a branch is taken.

The operations cover four bitwise functions, a wrapping add, a reversed subtract and two compare-and-set functions. The reversed subtract, called NADD, computes the second operand minus the first. Software gets an ordinary subtract by issuing NADD with the operands swapped. The two compare-and-set functions are equality and signed less-than. Each returns the value one or zero across the whole result word.

The data width is a parameter with a default of 16. A second parameter chooses how the adder is built: either a behavioural sum or an explicit ripple-carry chain.

Top module: `alu16_core`

## Requirements
- R1: Operation code 0 drives the result with the bitwise AND of A and B.
- R2: Operation code 1 drives the result with the bitwise OR of A and B.
- R3: Operation code 2 drives the result with the bitwise XOR of A and B.
- R4: Operation code 3 drives the result with the bitwise inverse of (A OR B).
- R5: Operation code 4 drives the result with A + B modulo 2^16; a carry out of bit 15 is dropped without any indication (for example, 16'hFFFF + 16'h0001 gives 16'h0000).
- R6: Operation code 5 drives the result with B - A modulo 2^16 (for example, A = 16'h0001 and B = 16'h0000 gives 16'hFFFF).
- R7: Operation code 6 drives the result with 16'h0001 when A equals B, and with 16'h0000 otherwise.
- R8: Operation code 7 drives the result with 16'h0001 when A is less than B as signed two's-complement numbers, and with 16'h0000 otherwise (for example, A = 16'h8000 and B = 16'h0001 gives 16'h0001).
- R9: The zero output is 1 exactly when every bit of the result is 0, for every operation code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 3 | Operation selector (codes as listed in R1 to R8) |
| a_i | input | 16 | First operand A |
| b_i | input | 16 | Second operand B |
| result_o | output | 16 | Operation result |
| zero_o | output | 1 | High when result_o is all zeros |

## Verification
The block has no storage, so any internal fault appears at the ports in the same cycle as the stimulus that exposes it. No later cycle can mask or reveal it.

A broken carry link in the adder shows up only when a carry must cross that bit. The bench therefore applies long carry and borrow runs, such as all-ones plus one and zero minus one. A sign-handling fault in the less-than function shows up only when the two operands have opposite signs, so the bench pairs negative and positive values. A wrong selector decode gives a wrong result word in the first cycle that uses the affected code. A faulty zero detector disagrees with a result word that is visible on the same cycle.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

   typedef enum logic [2:0] {
      OP_AND  = 3'd0,
      OP_OR   = 3'd1,
      OP_XOR  = 3'd2,
      OP_NOR  = 3'd3,
      OP_ADD  = 3'd4,
      OP_NADD = 3'd5,
      OP_SEQ  = 3'd6,
      OP_SLT  = 3'd7
   } alu_op_e;

   localparam int ADDER_BEHAVIOURAL = 0;
   localparam int ADDER_RIPPLE      = 1;

endpackage

// File: rtl/alu_logic_unit.sv
module alu_logic_unit #(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic [WIDTH-1:0] and_o,
   output logic [WIDTH-1:0] or_o,
   output logic [WIDTH-1:0] xor_o,
   output logic [WIDTH-1:0] nor_o
);

   assign and_o = a_i & b_i;
   assign or_o  = a_i | b_i;
   assign xor_o = a_i ^ b_i;
   assign nor_o = ~(a_i | b_i);

endmodule

// File: rtl/alu_add_unit.sv
module alu_add_unit #(
   parameter int WIDTH     = 16,
   parameter int ADDER_IMPL = alu16_pkg::ADDER_BEHAVIOURAL
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             negate_a_i,
   output logic [WIDTH-1:0] sum_o
);

   logic [WIDTH-1:0] x_op;
   logic [WIDTH-1:0] y_op;
   logic             cin;

   // NADD: B + ~A + 1 = B - A ; ADD: A + B
   assign x_op = negate_a_i ? b_i  : a_i;
   assign y_op = negate_a_i ? ~a_i : b_i;
   assign cin  = negate_a_i;

   generate
      if (ADDER_IMPL == alu16_pkg::ADDER_RIPPLE) begin : g_ripple
         logic [WIDTH-1:0] carry;
         assign carry[0] = cin;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign sum_o[i] = x_op[i] ^ y_op[i] ^ carry[i];
            if (i < WIDTH-1) begin : g_link
               assign carry[i+1] = (x_op[i] & y_op[i]) |
                                   (carry[i] & (x_op[i] ^ y_op[i]));
            end
         end
      end else begin : g_behav
         assign sum_o = x_op + y_op + {{(WIDTH-1){1'b0}}, cin};
      end
   endgenerate

endmodule

// File: rtl/alu_cmp_unit.sv
module alu_cmp_unit #(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic             eq_o,
   output logic             lt_o
);

   assign eq_o = (a_i == b_i);
   assign lt_o = ($signed(a_i) < $signed(b_i));

endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] value_i,
   output logic             zero_o
);

   assign zero_o = ~(|value_i);

endmodule

// File: rtl/alu16_core.sv
module alu16_core #(
   parameter int WIDTH      = 16,
   parameter int ADDER_IMPL = alu16_pkg::ADDER_RIPPLE
) (
   input  logic [2:0]       op_i,
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic [WIDTH-1:0] result_o,
   output logic             zero_o
);
   import alu16_pkg::*;

   localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("alu16_core: WIDTH must be at least 2");
      end
      if (ADDER_IMPL != ADDER_BEHAVIOURAL && ADDER_IMPL != ADDER_RIPPLE) begin : g_bad_impl
         $error("alu16_core: unknown ADDER_IMPL");
      end
   endgenerate

   alu_op_e          op;
   logic [WIDTH-1:0] and_v, or_v, xor_v, nor_v, sum_v;
   logic             eq_v, lt_v;

   assign op = alu_op_e'(op_i);

   alu_logic_unit #(.WIDTH(WIDTH)) u_logic (
      .a_i   (a_i),
      .b_i   (b_i),
      .and_o (and_v),
      .or_o  (or_v),
      .xor_o (xor_v),
      .nor_o (nor_v)
   );

   alu_add_unit #(.WIDTH(WIDTH), .ADDER_IMPL(ADDER_IMPL)) u_add (
      .a_i        (a_i),
      .b_i        (b_i),
      .negate_a_i (op == OP_NADD),
      .sum_o      (sum_v)
   );

   alu_cmp_unit #(.WIDTH(WIDTH)) u_cmp (
      .a_i  (a_i),
      .b_i  (b_i),
      .eq_o (eq_v),
      .lt_o (lt_v)
   );

   always_comb begin
      unique case (op)
         OP_AND:  result_o = and_v;
         OP_OR:   result_o = or_v;
         OP_XOR:  result_o = xor_v;
         OP_NOR:  result_o = nor_v;
         OP_ADD:  result_o = sum_v;
         OP_NADD: result_o = sum_v;
         OP_SEQ:  result_o = eq_v ? ONE : '0;
         OP_SLT:  result_o = lt_v ? ONE : '0;
         default: result_o = '0;
      endcase
   end

   alu_zero_detect #(.WIDTH(WIDTH)) u_zero (
      .value_i (result_o),
      .zero_o  (zero_o)
   );

   // Checks placed next to the result mux and the zero detector
   always_comb begin
      if (!$isunknown({op_i, a_i, b_i})) begin
         if (op == OP_XOR)
            assert_xor_R3: assert (result_o == ((a_i | b_i) & ~(a_i & b_i)));
         if (op == OP_ADD)
            assert_add_wrap_R5: assert ((result_o - b_i) == a_i);
         if (op == OP_NADD)
            assert_nadd_R6: assert ((result_o + a_i) == b_i);
         if (op == OP_SEQ)
            assert_seq_bool_R7: assert (result_o[WIDTH-1:1] == '0 && result_o[0] == (a_i == b_i));
         if (op == OP_SLT && a_i == b_i)
            assert_slt_equal_R8: assert (result_o == '0);
         assert_zero_flag_R9: assert (zero_o == (result_o == '0));
      end
   end

endmodule

// File: tb/alu16_core_tb.sv
module alu16_core_tb;

   logic        clk = 1'b0;
   logic [2:0]  op;
   logic [15:0] a, b;
   logic [15:0] result;
   logic        zero;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   logic [31:0] lfsr = 32'h1BADF00D;

   always #10 clk = ~clk;   // 50 MHz

   alu16_core u_dut (
      .op_i     (op),
      .a_i      (a),
      .b_i      (b),
      .result_o (result),
      .zero_o   (zero)
   );

   function automatic string req_tag(input int code);
      case (code)
         0: return "R1";
         1: return "R2";
         2: return "R3";
         3: return "R4";
         4: return "R5";
         5: return "R6";
         6: return "R7";
         default: return "R8";
      endcase
   endfunction

   function automatic logic [15:0] ref_model(input int code, input logic [15:0] x, input logic [15:0] y);
      int sx, sy, tmp;
      sx = (x >= 16'h8000) ? int'(x) - 65536 : int'(x);
      sy = (y >= 16'h8000) ? int'(y) - 65536 : int'(y);
      case (code)
         0: return x & y;
         1: return x | y;
         2: return x ^ y;
         3: return ~(x | y);
         4: begin tmp = (int'(x) + int'(y)) % 65536; return tmp[15:0]; end
         5: begin tmp = (int'(y) - int'(x) + 65536) % 65536; return tmp[15:0]; end
         6: return (x == y) ? 16'd1 : 16'd0;
         default: return (sx < sy) ? 16'd1 : 16'd0;
      endcase
   endfunction

   task automatic apply(input int code, input logic [15:0] x, input logic [15:0] y);
      logic [15:0] exp_r;
      @(negedge clk);
      op = code[2:0];
      a  = x;
      b  = y;
      exp_r = ref_model(code, x, y);
      @(posedge clk);
      #5;
      checks++;
      if (result !== exp_r) begin
         fails++;
         $display("FAIL %s op=%0d a=%h b=%h result actual=%h expected=%h",
                  req_tag(code), code, x, y, result, exp_r);
      end
      checks++;
      if (zero !== (exp_r == 16'h0000)) begin
         fails++;
         $display("FAIL R9 op=%0d a=%h b=%h zero actual=%b expected=%b",
                  code, x, y, zero, (exp_r == 16'h0000));
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired actual=%0d expected<=150000", cycles);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      op = 3'd0; a = 16'h0000; b = 16'h0000;
      // Initial state: AND of zeros, zero flag high (R1, R9)
      apply(0, 16'h0000, 16'h0000);
      // R1..R4 bitwise patterns
      apply(0, 16'hF0F0, 16'hFF00);
      apply(1, 16'h0F0F, 16'h00F0);
      apply(2, 16'hAAAA, 16'hAAAA);
      apply(3, 16'h0000, 16'h0000);
      apply(3, 16'h8001, 16'h7FFE);
      // R5 wrap
      apply(4, 16'hFFFF, 16'h0001);
      apply(4, 16'h7FFF, 16'h0001);
      // R6 B - A, borrow through all bits, equal operands
      apply(5, 16'h0001, 16'h0000);
      apply(5, 16'h1234, 16'h1234);
      apply(5, 16'h0003, 16'h0010);
      // R7 equality
      apply(6, 16'hBEEF, 16'hBEEF);
      apply(6, 16'hBEEF, 16'hBEEE);
      // R8 signed compare corners
      apply(7, 16'h8000, 16'h0001);
      apply(7, 16'h0001, 16'h8000);
      apply(7, 16'hFFFF, 16'h0000);
      apply(7, 16'h5555, 16'h5555);
      apply(7, 16'h8000, 16'h7FFF);
      // Pseudo-random sweep over every code
      for (int i = 0; i < 2400; i++) begin
         logic [15:0] ra, rb;
         lfsr = lfsr ^ (lfsr << 13);
         lfsr = lfsr ^ (lfsr >> 17);
         lfsr = lfsr ^ (lfsr << 5);
         ra = lfsr[15:0];
         rb = (i % 5 == 0) ? lfsr[15:0] : lfsr[31:16];
         apply(i % 8, ra, rb);
      end
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule